// File: doc/BRIEF.md
# Link Speed Retrain Sequencer

This block changes the speed of a serial link by driving the link's express capability registers through a configuration access port. Software or a management engine gives it three things: the byte offset of the capability structure, a target speed code and a poll limit. It then runs the whole retrain procedure without further help. It raises a one-cycle completion pulse and reports whether the link came up at the requested speed. It also reports the current speed and the negotiated width that the link status shows at the end.

The sequence is ordered to avoid a race with the link's own state machine. The new target speed is written first, with nothing else changed. The sequencer then waits until the link reports that no training is running. Only after that does it read the link control register and write it back once, with the retrain request added and every other field unchanged. It then waits for the training that this request started to finish, and takes the final status from that last poll. Each polling phase is bounded by a programmable cycle count, so a link that never settles still ends in a completion with a failure result.

Top module: `link_speed_retrain_seq`

## Requirements
- R1: A `start` pulse while idle latches `cap_base` and `target_speed` and begins a run. A `start` while a run is in progress has no effect on the run.
- R2: The first accesses are a 32-bit read (byte enables 4'b1111) and then a 32-bit write of the dword at `cap_base`+0x30. The write replaces bits [3:0] with the target code and returns bits [31:4] exactly as read.
- R3: No access to the link control lanes happens until the target speed write has completed and a status poll has returned the training bit clear. A status poll is a read of the dword at `cap_base`+0x10 with byte enables 4'b1100; the status word is `cfg_rdata[31:16]` and the training bit is bit 11 of that word.
- R4: The link control register is read with byte enables 4'b0011 at `cap_base`+0x10, with its value in `cfg_rdata[15:0]`. It is then written exactly once with the same enables, as the read value OR 0x0020, so only bit 5 is set.
- R5: After the retrain write, status is polled again until the training bit reads 0. `cur_speed` then shows status bits [3:0] and `link_width` shows bits [9:4] of that final poll, for example width code 4 for x4 or 12 for x12.
- R6: `success` is 1 only when the final poll shows training clear and a current speed equal to the latched target. Otherwise it is 0.
- R7: Each polling phase counts cycles from its entry. A poll that returns the training bit set once the count has reached `poll_limit` ends the run with `success` 0. If this happens in the first phase, link control is never read or written.
- R8: Only one access is outstanding at a time. `cfg_req` and all request fields stay stable from the start of a request until the cycle `cfg_ack` is high. Byte enables are always 4'b0011, 4'b1100 or 4'b1111.
- R9: `done` is a single-cycle pulse. `success`, `cur_speed` and `link_width` keep their values after it until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a retrain run (accepted while idle) |
| cap_base | input | ADDR_W | Dword-aligned byte offset of the express capability |
| target_speed | input | 4 | Target speed code (1 to 7) |
| poll_limit | input | TMO_W | Cycle limit for each polling phase |
| cfg_req | output | 1 | Configuration access request |
| cfg_we | output | 1 | 1 = write, 0 = read |
| cfg_addr | output | ADDR_W | Dword-aligned byte address |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data, lane aligned |
| cfg_ack | input | 1 | Access complete; read data valid |
| cfg_rdata | input | 32 | Read data, lane aligned |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Link reached the target speed |
| cur_speed | output | 4 | Current speed from the final status read |
| link_width | output | 6 | Negotiated width from the final status read |

## Verification
The bench builds the block with its default parameters: a 12-bit address, which covers the extended configuration space, and a 16-bit poll counter. Every target code from 1 to 7 is run against two link speed ceilings and two amounts of pre-existing training, with widths cycled through all legal codes, so that both matching and mismatching final speeds occur. Short poll limits with training stuck on in either phase cover both timeout exits. A register model answers the accesses and flags any access that comes out of order or uses a wrong lane.

// File: rtl/lsr_pkg.sv
// Package: shared encodings for the link speed retrain sequencer.
// Assumes the capability base is dword aligned, so control and status
// share one dword at offset 0x10.
package lsr_pkg;
    localparam int OFS_LCTL   = 'h10;   // control (lanes 0-1) and status (lanes 2-3)
    localparam int OFS_LCTL2  = 'h30;   // holds the target speed field
    localparam int RETRAIN_BIT = 5;
    localparam int TRAIN_BIT   = 11;
    localparam logic [3:0] BE_LO   = 4'b0011;
    localparam logic [3:0] BE_HI   = 4'b1100;
    localparam logic [3:0] BE_FULL = 4'b1111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TGT,
        ST_WR_TGT,
        ST_POLL_PRE,
        ST_RD_CTL,
        ST_WR_CTL,
        ST_POLL_POST
    } seq_state_t;
endpackage

// File: rtl/lsr_poll_timer.sv
// Poll timer: counts cycles while enabled and saturates at the limit.
// Assumes clr is held whenever no polling phase is active.
module lsr_poll_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    // Count phase cycles and stop at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (en && (cnt < limit))
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= limit);
endmodule

// File: rtl/lsr_status_fields.sv
// Status field splitter: extracts speed, width and the training flag
// from the 16-bit link status word. Purely combinational.
module lsr_status_fields (
    input  logic       train_bit,
    input  logic [9:0] low_fields,
    output logic [3:0] speed,
    output logic [5:0] width,
    output logic       training
);
    // Field split of the status word.
    always_comb begin
        speed    = low_fields[3:0];
        width    = low_fields[9:4];
        training = train_bit;
    end
endmodule

// File: rtl/lsr_req_gen.sv
// Request generator: maps the sequencer state onto address, direction,
// byte enables and write data of the configuration access port.
// Assumes base is dword aligned.
module lsr_req_gen
    import lsr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  seq_state_t        state,
    input  logic [ADDR_W-1:0] base,
    input  logic [3:0]        tgt,
    input  logic [31:4]       tgt_reg_hi,
    input  logic [15:0]       ctl_val,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [3:0]        be,
    output logic [31:0]       wdata
);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_LCTL);
    localparam logic [ADDR_W-1:0] A_CTL2 = ADDR_W'(OFS_LCTL2);
    localparam logic [15:0] RETRAIN_MASK = 16'(1) << RETRAIN_BIT;

    // Decode the access fields for the current state.
    always_comb begin
        req   = 1'b1;
        we    = 1'b0;
        addr  = base + A_CTL;
        be    = BE_HI;
        wdata = '0;
        unique case (state)
            ST_RD_TGT: begin
                addr = base + A_CTL2;
                be   = BE_FULL;
            end
            ST_WR_TGT: begin
                addr  = base + A_CTL2;
                be    = BE_FULL;
                we    = 1'b1;
                wdata = {tgt_reg_hi, tgt};
            end
            ST_RD_CTL: be = BE_LO;
            ST_WR_CTL: begin
                be    = BE_LO;
                we    = 1'b1;
                wdata = {16'h0000, ctl_val | RETRAIN_MASK};
            end
            ST_POLL_PRE, ST_POLL_POST: be = BE_HI;
            default: req = 1'b0;
        endcase
    end
endmodule

// File: rtl/link_speed_retrain_seq.sv
// Link speed retrain sequencer (top). Writes the target speed, waits for
// idle training, sets the retrain request by read-modify-write, waits for
// training to end and reports the outcome.
// Assumes one-access-at-a-time config port with a single-cycle ack.
module link_speed_retrain_seq
    import lsr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cap_base,
    input  logic [3:0]        target_speed,
    input  logic [TMO_W-1:0]  poll_limit,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic              cfg_ack,
    input  logic [31:0]       cfg_rdata,
    output logic              done,
    output logic              success,
    output logic [3:0]        cur_speed,
    output logic [5:0]        link_width
);
    seq_state_t        state;
    logic [ADDR_W-1:0] base_q;
    logic [3:0]        tgt_q;
    logic [31:4]       tgt_reg_hi;
    logic [15:0]       ctl_q;
    logic [3:0]        st_speed;
    logic [5:0]        st_width;
    logic              st_training;
    logic              polling;
    logic              expired;

    assign polling = (state == ST_POLL_PRE) || (state == ST_POLL_POST);

    lsr_status_fields u_fields (
        .train_bit  (cfg_rdata[16 + TRAIN_BIT]),
        .low_fields (cfg_rdata[25:16]),
        .speed      (st_speed),
        .width      (st_width),
        .training   (st_training)
    );

    lsr_poll_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!polling),
        .en      (polling),
        .limit   (poll_limit),
        .expired (expired)
    );

    lsr_req_gen #(.ADDR_W(ADDR_W)) u_req (
        .state      (state),
        .base       (base_q),
        .tgt        (tgt_q),
        .tgt_reg_hi (tgt_reg_hi),
        .ctl_val    (ctl_q),
        .req        (cfg_req),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .be         (cfg_be),
        .wdata      (cfg_wdata)
    );

    // Sequencer: step through the retrain order, one access per state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            base_q     <= '0;
            tgt_q      <= '0;
            tgt_reg_hi <= '0;
            ctl_q      <= '0;
            done       <= 1'b0;
            success    <= 1'b0;
            cur_speed  <= '0;
            link_width <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    base_q  <= cap_base;
                    tgt_q   <= target_speed;
                    success <= 1'b0;
                    state   <= ST_RD_TGT;
                end
                ST_RD_TGT: if (cfg_ack) begin
                    tgt_reg_hi <= cfg_rdata[31:4];
                    state      <= ST_WR_TGT;
                end
                ST_WR_TGT: if (cfg_ack) state <= ST_POLL_PRE;
                ST_POLL_PRE: if (cfg_ack) begin
                    cur_speed  <= st_speed;
                    link_width <= st_width;
                    if (!st_training) begin
                        state <= ST_RD_CTL;
                    end else if (expired) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_RD_CTL: if (cfg_ack) begin
                    ctl_q <= cfg_rdata[15:0];
                    state <= ST_WR_CTL;
                end
                ST_WR_CTL: if (cfg_ack) state <= ST_POLL_POST;
                ST_POLL_POST: if (cfg_ack) begin
                    cur_speed  <= st_speed;
                    link_width <= st_width;
                    if (!st_training) begin
                        success <= (st_speed == tgt_q);
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (expired) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lsr_checker.sv
// Checker: protocol and result properties of the retrain sequencer,
// attached to every instance of the top module through bind.
module lsr_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cfg_req,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic              cfg_ack,
    input logic              done,
    input logic              success,
    input logic [3:0]        cur_speed,
    input logic [3:0]        tgt_q
);
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) && $stable(cfg_we) && $stable(cfg_be) && $stable(cfg_wdata)); // R8
    AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_be == 4'b0011 || cfg_be == 4'b1100 || cfg_be == 4'b1111)); // R8
    AST_CTL_WRITE_RETRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && cfg_we && cfg_be == 4'b0011 |-> cfg_wdata[5]); // R4
    AST_TGT_WRITE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && cfg_we && cfg_be == 4'b1111 |-> cfg_wdata[3:0] == tgt_q); // R2
    AST_SUCCESS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done && success |-> cur_speed == tgt_q); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(success) || done); // R9
endmodule

bind link_speed_retrain_seq lsr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_req   (cfg_req),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_ack   (cfg_ack),
    .done      (done),
    .success   (success),
    .cur_speed (cur_speed),
    .tgt_q     (tgt_q)
);

// File: tb/test_link_speed_retrain_seq.sv
// Bench: register model on the config port, sweep of targets, ceilings,
// widths and training delays, plus timeout cases.
module test_link_speed_retrain_seq;
    localparam int ADDR_W = 12;
    localparam int TMO_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] cap_base = '0;
    logic [3:0]        target_speed = '0;
    logic [TMO_W-1:0]  poll_limit = 16'd40;
    logic              cfg_req, cfg_we, cfg_ack = 1'b0;
    logic [ADDR_W-1:0] cfg_addr;
    logic [3:0]        cfg_be;
    logic [31:0]       cfg_wdata, cfg_rdata = '0;
    logic              done, success;
    logic [3:0]        cur_speed;
    logic [5:0]        link_width;

    int checks = 0;
    int errors = 0;

    // model state
    logic [31:0] m_tgtreg;
    logic [15:0] m_ctl, m_ctl_written;
    logic [3:0]  m_speed, m_cap;
    logic [5:0]  m_width, m_new_width;
    int  m_pre_busy, m_post_busy, m_pre_cnt, m_post_cnt;
    bit  m_stuck_pre, m_stuck_post, m_retrained, m_tgt_written, m_last_busy;
    int  m_n_tgt_wr, m_n_ctl_wr, m_order_err, m_bad;

    link_speed_retrain_seq #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) i_link_speed_retrain_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cap_base(cap_base),
        .target_speed(target_speed), .poll_limit(poll_limit),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
        .done(done), .success(success), .cur_speed(cur_speed), .link_width(link_width)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Config responder: answers one request with a one-cycle ack.
    initial begin
        forever begin
            @(negedge clk);
            if (cfg_ack) begin
                cfg_ack = 1'b0;
            end else if (cfg_req) begin
                cfg_ack = 1'b1;
                cfg_rdata = '0;
                if (cfg_addr == cap_base + 12'h30 && cfg_be == 4'b1111) begin
                    if (cfg_we) begin
                        m_tgtreg = cfg_wdata;
                        m_n_tgt_wr++;
                        m_tgt_written = 1;
                    end else cfg_rdata = m_tgtreg;
                end else if (cfg_addr == cap_base + 12'h10 && cfg_be == 4'b1100 && !cfg_we) begin
                    if (m_retrained) begin
                        m_last_busy = m_stuck_post || (m_post_cnt < m_post_busy);
                        m_post_cnt++;
                    end else begin
                        m_last_busy = m_stuck_pre || (m_pre_cnt < m_pre_busy);
                        m_pre_cnt++;
                    end
                    cfg_rdata = {4'h0, m_last_busy, 1'b0, m_width, m_speed, 16'h0000};
                end else if (cfg_addr == cap_base + 12'h10 && cfg_be == 4'b0011) begin
                    if (!m_tgt_written || m_last_busy) m_order_err++;
                    if (cfg_we) begin
                        m_ctl_written = cfg_wdata[15:0];
                        m_n_ctl_wr++;
                        m_retrained = 1;
                        m_speed = (m_tgtreg[3:0] < m_cap) ? m_tgtreg[3:0] : m_cap;
                        m_width = m_new_width;
                    end else cfg_rdata = {16'h0000, m_ctl};
                end else begin
                    m_bad++;
                end
            end
        end
    end

    task automatic run_case(input logic [3:0] tgt, input logic [3:0] cap, input int pre_busy,
                            input bit stuck_pre, input bit stuck_post, input logic [5:0] wid,
                            input logic [15:0] ctl0, input logic [31:0] reg0,
                            input logic [ADDR_W-1:0] base, input bit poke_busy);
        int  cyc;
        bit  got;
        logic [3:0] exp_speed;
        logic [5:0] exp_width;
        bit  exp_ok;
        m_tgtreg = reg0; m_ctl = ctl0; m_ctl_written = '0;
        m_speed = 4'd1; m_width = 6'd1; m_cap = cap; m_new_width = wid;
        m_pre_busy = pre_busy; m_post_busy = 2; m_pre_cnt = 0; m_post_cnt = 0;
        m_stuck_pre = stuck_pre; m_stuck_post = stuck_post;
        m_retrained = 0; m_tgt_written = 0; m_last_busy = 1;
        m_n_tgt_wr = 0; m_n_ctl_wr = 0; m_order_err = 0; m_bad = 0;
        poll_limit = (stuck_pre || stuck_post) ? 16'd10 : 16'd40;
        @(negedge clk);
        cap_base = base; target_speed = tgt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            @(negedge clk);
            target_speed = 4'd7; start = 1'b1;   // R1: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        got = 0;
        for (cyc = 0; cyc < 3000 && !got; cyc++) begin
            @(negedge clk);
            if (done) got = 1;
        end
        check(got, "R7 done within watchdog", got, 1);
        if (!got) return;
        exp_speed = stuck_pre ? 4'd1 : ((tgt < cap) ? tgt : cap);
        exp_width = stuck_pre ? 6'd1 : wid;
        exp_ok = !stuck_pre && !stuck_post && (exp_speed == tgt);
        check(m_tgtreg == {reg0[31:4], tgt}, "R2 target field", m_tgtreg, {reg0[31:4], tgt});
        check(m_n_tgt_wr == 1, "R2 target write count", m_n_tgt_wr, 1);
        check(m_order_err == 0, "R3 access order", m_order_err, 0);
        check(m_bad == 0, "R8 access lane/address", m_bad, 0);
        if (stuck_pre) begin
            check(m_n_ctl_wr == 0, "R7 no control write on early timeout", m_n_ctl_wr, 0);
        end else begin
            check(m_n_ctl_wr == 1, "R4 control write count", m_n_ctl_wr, 1);
            check(m_ctl_written == (ctl0 | 16'h0020), "R4 control value", m_ctl_written, ctl0 | 16'h0020);
        end
        check(success == exp_ok, "R6 success", success, exp_ok);
        check(cur_speed == exp_speed, "R5 speed", cur_speed, exp_speed);
        check(link_width == exp_width, "R5 width", link_width, exp_width);
        @(negedge clk);
        @(negedge clk);
        check(!done, "R9 done single pulse", done, 0);
        check(success == exp_ok && cur_speed == exp_speed, "R9 results held", success, exp_ok);
    endtask

    initial begin
        logic [5:0] widths [7];
        widths = '{6'd1, 6'd2, 6'd4, 6'd8, 6'd12, 6'd16, 6'd32};
        repeat (3) @(negedge clk);
        check(!done && !cfg_req && !success, "R9 reset state", {done, cfg_req, success}, 0);
        rst_n = 1'b1;
        for (int t = 1; t <= 7; t++)
            for (int c = 0; c < 2; c++)
                for (int p = 0; p < 2; p++)
                    run_case(4'(t), c ? 4'd5 : 4'd3, p * 2, 0, 0, widths[(t + c + p) % 7],
                             16'h0040 + 16'(t * 3 + c), 32'hA5A5_0000 + 32'(t << 8),
                             12'h040 + 12'(c * 16'h100), 0);
        run_case(4'd2, 4'd3, 1, 0, 0, 6'd8, 16'h0151, 32'h1234_567F, 12'h0A0, 1); // R1
        run_case(4'd3, 4'd3, 0, 1, 0, 6'd4, 16'h0043, 32'h0000_0001, 12'h040, 0); // R7 phase 1
        run_case(4'd3, 4'd3, 0, 0, 1, 6'd4, 16'h0040, 32'hFFFF_FFF1, 12'h040, 0); // R7 phase 2
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule